// File: doc/BRIEF.md
# Binary Strip Hit Pipeline

This block takes the binary outputs of 128 strip discriminators and captures them once per bunch clock into an input register. A configuration input chooses the capture rule. In level capture, a channel reports a hit in every cycle in which it is high. In rise capture, it reports a hit only in the cycle in which it goes from low to high, which keeps the readout volume down. Each captured 128-bit hit word goes into a circular store of 132 columns, and one column is written every clock.

A trigger reaches back into the store by a programmable latency and pulls out three adjacent time slices. These appear on the output port on three consecutive clocks, each marked by a valid strobe and a two-bit time-bin index. A trigger that arrives while a burst is still running is counted. Counted triggers are served back to back, and the counter holds at most seven.

Top module: `strip_hit_pipe`

## Requirements
- R1: All 128 discriminator inputs are captured at every rising clock edge. The hit word produced at one edge is written into the store at the next edge.
- R2: With `edge_mode` = 0 (level capture), bit i of a hit word is 1 exactly when channel i was high at that capture edge.
- R3: With `edge_mode` = 1 (rise capture), bit i is 1 only when channel i is high at this capture edge and was low at the previous one. A channel held high gives one hit. The history reads as all-low after reset, so a channel high at the first capture after reset gives a hit.
- R4: The store has 132 columns and a write pointer that advances by one every clock and wraps from 131 to 0.
- R5: A burst that starts at edge S with latency L (legal range 3 to 131) outputs, in time bin k (k = 0, 1, 2), the hit word produced at capture edge S-L-1+k.
- R6: A burst drives `out_valid` high for three consecutive cycles, starting one cycle after its start edge. `out_bin` reads 0, 1, 2 in turn.
- R7: A trigger sampled while idle, or at the edge that issues a burst's last bin, starts a burst at that edge. A trigger sampled at any other edge of a burst is counted. Counted triggers start bursts back to back, each addressed as if it had arrived at its own start edge.
- R8: The pending-trigger count stops at 7, and any further trigger that cannot start at once is dropped.
- R9: The active-low reset clears the write pointer, the capture history, the pending count and any burst in progress. `out_valid` stays low until a new trigger arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| edge_mode | input | 1 | 0 = level capture, 1 = rise capture |
| latency | input | 8 | Trigger look-back in clocks (3..131) |
| trig | input | 1 | Trigger, one per clock at most |
| disc_in | input | 128 | Discriminator outputs |
| out_valid | output | 1 | Burst time bin present |
| out_bin | output | 2 | Time-bin index 0..2 |
| out_data | output | 128 | Hit word of that time bin |

## Verification
The hardest state to reach from the ports is a long queue of counted triggers. That needs triggers on almost every clock while bursts are draining, so that the counter sits at its limit and later triggers are thrown away. Table rows put dense trigger masks on top of a pipeline already filled with hashed, walking and square-wave patterns. A cycle-level reference model, built from the requirements, predicts every beat, including those from triggers served late. Other rows run long enough for the write pointer to wrap, reach the latency extremes, or fire a trigger three clocks after reset so that bin 0 reads a column written while the history was still clear.

// File: rtl/shp_pkg.sv
`timescale 1ns/1ps
package shp_pkg;

  typedef enum logic {
    CAP_LEVEL = 1'b0,
    CAP_RISE  = 1'b1
  } cap_mode_e;

  // next position on a ring of the given depth
  function automatic int unsigned ring_next(input int unsigned pos, input int unsigned depth);
    return (pos == depth - 1) ? 0 : pos + 1;
  endfunction

endpackage

// File: rtl/shp_sampler.sv
`timescale 1ns/1ps
module shp_sampler
  import shp_pkg::*;
#(
  parameter int NCH = 128
) (
  input  logic           clk,
  input  logic           rst_n,
  input  cap_mode_e      mode,
  input  logic [NCH-1:0] din,
  output logic [NCH-1:0] hit
);

  logic [NCH-1:0] prev_q, prev_d;
  logic [NCH-1:0] hit_q, hit_d;
  logic           cap_en;

  assign cap_en = 1'b1;
  assign prev_d = din;

  // per-channel capture rule
  for (genvar i = 0; i < NCH; i++) begin : g_chan
    always_comb begin
      if (mode == CAP_RISE) hit_d[i] = din[i] & ~prev_q[i];
      else                  hit_d[i] = din[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      hit_q  <= '0;
    end else if (cap_en) begin
      prev_q <= prev_d;
      hit_q  <= hit_d;
    end
  end

  assign hit = hit_q;

endmodule

// File: rtl/shp_ring.sv
`timescale 1ns/1ps
module shp_ring
  import shp_pkg::*;
#(
  parameter int NCH   = 128,
  parameter int DEPTH = 132,
  parameter int PW    = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] wr_data,
  input  logic           rd_en,
  input  logic [PW-1:0]  rd_addr,
  output logic [PW-1:0]  wr_ptr,
  output logic [NCH-1:0] rd_data
);

  logic [NCH-1:0] mem [DEPTH];
  logic [PW-1:0]  wp_q, wp_d;
  logic           wr_en;
  logic [NCH-1:0] rd_q;

  assign wr_en = 1'b1;

  always_comb begin
    wp_d = wp_q;
    if (wr_en) wp_d = PW'(ring_next(int'(wp_q), DEPTH));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wp_q <= '0;
    else        wp_q <= wp_d;
  end

  // storage array: no reset, written every clock
  always_ff @(posedge clk) begin
    if (wr_en) mem[wp_q] <= wr_data;
  end

  // registered read port; a same-edge write returns the old column
  always_ff @(posedge clk) begin
    if (rd_en) rd_q <= mem[rd_addr];
  end

  assign wr_ptr  = wp_q;
  assign rd_data = rd_q;

endmodule

// File: rtl/shp_burst_ctl.sv
`timescale 1ns/1ps
module shp_burst_ctl
  import shp_pkg::*;
#(
  parameter int DEPTH = 132,
  parameter int PW    = $clog2(DEPTH),
  parameter int LAT_W = 8,
  parameter int BURST = 3,
  parameter int BW    = $clog2(BURST),
  parameter int QMAX  = 7,
  parameter int QW    = $clog2(QMAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic [LAT_W-1:0] latency,
  input  logic [PW-1:0]    wr_ptr,
  output logic             rd_en,
  output logic [PW-1:0]    rd_addr,
  output logic             out_valid,
  output logic [BW-1:0]    out_bin,
  output logic             svc_start,
  output logic [QW-1:0]    pend_cnt
);

  localparam int SW = ((LAT_W > PW) ? LAT_W : PW) + 1;

  logic          act_q, act_d;
  logic [BW-1:0] idx_q, idx_d;
  logic [PW-1:0] ptr_q, ptr_d;
  logic [QW-1:0] pend_q, pend_d;
  logic          vld_q;
  logic [BW-1:0] bin_q;

  logic [SW-1:0] lat_w, lat_c, wp_w, base_w;
  logic [PW-1:0] base;
  logic          can_start, want, start, last_bin;

  // look-back address: write pointer minus latency, modulo depth
  always_comb begin
    lat_w = SW'(latency);
    wp_w  = SW'(wr_ptr);
    lat_c = (lat_w >= SW'(DEPTH)) ? SW'(DEPTH - 1) : lat_w;
    if (wp_w >= lat_c) base_w = wp_w - lat_c;
    else               base_w = wp_w + SW'(DEPTH) - lat_c;
    base = base_w[PW-1:0];
  end

  always_comb begin
    last_bin  = (idx_q == BW'(BURST - 1));
    can_start = !act_q || last_bin;
    want      = trig || (pend_q != '0);
    start     = can_start && want;
  end

  // pending-trigger counter
  always_comb begin
    pend_d = pend_q;
    if (start && (pend_q != '0))
      pend_d = pend_q - QW'(1) + {{(QW-1){1'b0}}, trig};
    else if (!start && trig && (pend_q != QW'(QMAX)))
      pend_d = pend_q + QW'(1);
  end

  // burst sequencing
  always_comb begin
    act_d = act_q;
    idx_d = idx_q;
    ptr_d = ptr_q;
    if (act_q) begin
      idx_d = idx_q + BW'(1);
      ptr_d = PW'(ring_next(int'(ptr_q), DEPTH));
    end
    if (can_start) begin
      act_d = start;
      idx_d = '0;
      if (start) ptr_d = base;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      idx_q  <= '0;
      ptr_q  <= '0;
      pend_q <= '0;
      vld_q  <= 1'b0;
      bin_q  <= '0;
    end else begin
      act_q  <= act_d;
      idx_q  <= idx_d;
      ptr_q  <= ptr_d;
      pend_q <= pend_d;
      vld_q  <= act_q;
      if (act_q) bin_q <= idx_q;
    end
  end

  assign rd_en     = act_q;
  assign rd_addr   = ptr_q;
  assign out_valid = vld_q;
  assign out_bin   = bin_q;
  assign svc_start = start;
  assign pend_cnt  = pend_q;

endmodule

// File: rtl/strip_hit_pipe.sv
`timescale 1ns/1ps
module strip_hit_pipe
  import shp_pkg::*;
#(
  parameter int NCH   = 128,
  parameter int DEPTH = 132,
  parameter int LAT_W = 8,
  parameter int BURST = 3,
  parameter int QMAX  = 7,
  localparam int PW   = $clog2(DEPTH),
  localparam int BW   = $clog2(BURST),
  localparam int QW   = $clog2(QMAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             edge_mode,
  input  logic [LAT_W-1:0] latency,
  input  logic             trig,
  input  logic [NCH-1:0]   disc_in,
  output logic             out_valid,
  output logic [BW-1:0]    out_bin,
  output logic [NCH-1:0]   out_data
);

  logic [NCH-1:0] hit_word;
  logic [PW-1:0]  wr_ptr;
  logic           rd_en;
  logic [PW-1:0]  rd_addr;
  logic           svc_start;
  logic [QW-1:0]  pend_cnt;
  cap_mode_e      cap_mode;

  assign cap_mode = cap_mode_e'(edge_mode);

  shp_sampler #(.NCH(NCH)) u_samp (
    .clk  (clk),
    .rst_n(rst_n),
    .mode (cap_mode),
    .din  (disc_in),
    .hit  (hit_word)
  );

  shp_ring #(.NCH(NCH), .DEPTH(DEPTH), .PW(PW)) u_ring (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_data(hit_word),
    .rd_en  (rd_en),
    .rd_addr(rd_addr),
    .wr_ptr (wr_ptr),
    .rd_data(out_data)
  );

  shp_burst_ctl #(
    .DEPTH(DEPTH), .PW(PW), .LAT_W(LAT_W),
    .BURST(BURST), .BW(BW), .QMAX(QMAX), .QW(QW)
  ) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .trig     (trig),
    .latency  (latency),
    .wr_ptr   (wr_ptr),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .out_valid(out_valid),
    .out_bin  (out_bin),
    .svc_start(svc_start),
    .pend_cnt (pend_cnt)
  );

endmodule

// File: rtl/shp_chk.sv
`timescale 1ns/1ps
module shp_chk #(
  parameter int NCH   = 128,
  parameter int DEPTH = 132,
  parameter int PW    = 8,
  parameter int BW    = 2,
  parameter int QW    = 3,
  parameter int QMAX  = 7
) (
  input logic           clk,
  input logic           rst_n,
  input logic           edge_mode,
  input logic           trig,
  input logic [NCH-1:0] hit_word,
  input logic [PW-1:0]  wr_ptr,
  input logic           out_valid,
  input logic [BW-1:0]  out_bin,
  input logic           svc_start,
  input logic [QW-1:0]  pend_cnt
);

  // R3: in steady rise capture no channel hits twice in a row
  a_r3_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(edge_mode) && $past(edge_mode, 2)) |-> ((hit_word & $past(hit_word)) == '0));

  // R4: write pointer wraps at the last column
  a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ptr == PW'(DEPTH - 1)) |=> (wr_ptr == '0));

  // R4: write pointer stays inside the ring
  a_r4_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(wr_ptr) < DEPTH));

  // R6: a burst opens with bin 0
  a_r6_first_bin: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (out_bin == '0));

  // R6: bin 0 is followed by bin 1
  a_r6_bin0_next: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_bin == BW'(0)) |=> (out_valid && out_bin == BW'(1)));

  // R6: bin 1 is followed by bin 2
  a_r6_bin1_next: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_bin == BW'(1)) |=> (out_valid && out_bin == BW'(2)));

  // R8: a full counter stays full when a trigger cannot start
  a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_cnt == QW'(QMAX) && trig && !svc_start) |=> (pend_cnt == QW'(QMAX)));

endmodule

bind strip_hit_pipe shp_chk #(
  .NCH(NCH), .DEPTH(DEPTH), .PW(PW), .BW(BW), .QW(QW), .QMAX(QMAX)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .edge_mode(edge_mode),
  .trig     (trig),
  .hit_word (hit_word),
  .wr_ptr   (wr_ptr),
  .out_valid(out_valid),
  .out_bin  (out_bin),
  .svc_start(svc_start),
  .pend_cnt (pend_cnt)
);

// File: tb/strip_hit_pipe_tb.sv
`timescale 1ns/1ps
module strip_hit_pipe_tb;

  typedef struct packed {
    logic       rise;
    logic [7:0] lat;
    logic [1:0] psel;
    logic [7:0] warm;
    logic [15:0] tmask;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 8'd3,   2'd2, 8'd140, 16'h0001},  // R2 R5 R6 shortest latency
    '{1'b0, 8'd131, 2'd2, 8'd250, 16'h0001},  // R4 R5 wrapped pointer, longest latency
    '{1'b0, 8'd40,  2'd3, 8'd140, 16'h0009},  // R7 trigger on last-bin edge
    '{1'b0, 8'd70,  2'd0, 8'd140, 16'h0006},  // R7 queued trigger
    '{1'b1, 8'd3,   2'd1, 8'd3,   16'h0001},  // R3 R9 held high after reset
    '{1'b1, 8'd20,  2'd3, 8'd140, 16'h0101},  // R3 square waves
    '{1'b1, 8'd131, 2'd2, 8'd200, 16'h0003},  // R3 R7 longest latency
    '{1'b0, 8'd10,  2'd2, 8'd140, 16'hFFFF},  // R8 saturation
    '{1'b1, 8'd100, 2'd0, 8'd140, 16'h0E07},  // R7 mixed queueing
    '{1'b0, 8'd3,   2'd1, 8'd3,   16'h0001},  // R2 R9 level after reset
    '{1'b0, 8'd77,  2'd0, 8'd140, 16'hFFF0}   // R8 late dense triggers
  };

  logic         clk = 1'b0;
  logic         rst_n;
  logic         edge_mode;
  logic [7:0]   latency;
  logic         trig;
  logic [127:0] disc_in;
  logic         out_valid;
  logic [1:0]   out_bin;
  logic [127:0] out_data;

  int errs = 0;
  int checks = 0;
  bit done = 0;

  // reference model state
  int           e = 0;
  logic [127:0] hitq [512];
  logic [127:0] prev_m;
  bit           act_m;
  int           idx_m, svc_m, pend_m;
  bit           ev;
  int           eb;
  logic [127:0] ed;
  bit           m_rise;
  int           m_lat;

  strip_hit_pipe u_dut (
    .clk(clk), .rst_n(rst_n), .edge_mode(edge_mode), .latency(latency),
    .trig(trig), .disc_in(disc_in), .out_valid(out_valid),
    .out_bin(out_bin), .out_data(out_data)
  );

  always #2.5 clk = ~clk;

  function automatic logic [31:0] mix(input int c);
    logic [31:0] x;
    x = 32'(c) * 32'h9E3779B1;
    x = x ^ (x >> 15);
    x = x * 32'h85EBCA6B;
    x = x ^ (x >> 13);
    return x;
  endfunction

  function automatic logic [127:0] pat(input logic [1:0] s, input int c);
    logic [127:0] v;
    v = '0;
    case (s)
      2'd0: begin v[c % 128] = 1'b1; v[(c * 5) % 128] = 1'b1; end
      2'd1: v = '1;
      2'd2: for (int w = 0; w < 4; w++) v[w*32 +: 32] = mix(c * 4 + w);
      default: for (int i = 0; i < 128; i++) v[i] = (((c + i) / 4) % 2) == 1;
    endcase
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(input bit t, input bit r, input logic [127:0] d);
    logic [127:0] h;
    bit can, start;
    @(negedge clk);
    check(out_valid === ev, "R6", "out_valid", 128'(out_valid), 128'(ev));
    if (ev) begin
      check(out_bin === eb[1:0], "R6", "out_bin", 128'(out_bin), 128'(eb));
      check(out_data === ed, m_rise ? "R1 R3 R5" : "R1 R2 R5", "out_data", out_data, ed);
    end
    rst_n = r; trig = t; disc_in = d; edge_mode = m_rise; latency = 8'(m_lat);
    if (!r) begin
      // R9: everything cleared
      hitq[e & 511] = '0; prev_m = '0; act_m = 0; idx_m = 0; pend_m = 0; ev = 0;
    end else begin
      h = m_rise ? (d & ~prev_m) : d;
      hitq[e & 511] = h;
      prev_m = d;
      ev = act_m;
      if (act_m) begin
        eb = idx_m;
        ed = hitq[(svc_m - m_lat - 1 + idx_m) & 511];
      end
      can = !act_m || (idx_m == 2);
      start = can && (t || pend_m > 0);
      if (start && pend_m > 0) pend_m = pend_m - 1 + int'(t);
      else if (!start && t && pend_m < 7) pend_m++;
      if (act_m) idx_m++;
      if (can) begin
        act_m = start; idx_m = 0;
        if (start) svc_m = e;
      end
    end
    e++;
  endtask

  task automatic do_reset(input int n, input logic [1:0] psel);
    for (int j = 0; j < n; j++) step(1'b0, 1'b0, pat(psel, e));
  endtask

  initial begin
    rst_n = 1'b0; edge_mode = 1'b0; latency = 8'd3; trig = 1'b0; disc_in = '0;
    m_rise = 0; m_lat = 3; ev = 0; act_m = 0; idx_m = 0; pend_m = 0; prev_m = '0;
    svc_m = 0; eb = 0; ed = '0;

    for (int v = 0; v < NV; v++) begin
      m_rise = VEC[v].rise;
      m_lat  = int'(VEC[v].lat);
      do_reset(3, VEC[v].psel);
      check(out_valid === 1'b0, "R9", "out_valid after reset", 128'(out_valid), 128'(0));
      for (int j = 0; j < int'(VEC[v].warm); j++) step(1'b0, 1'b1, pat(VEC[v].psel, e));
      for (int j = 0; j < 16; j++) step(VEC[v].tmask[j], 1'b1, pat(VEC[v].psel, e));
      for (int j = 0; j < 40; j++) step(1'b0, 1'b1, pat(VEC[v].psel, e));
    end

    // R9: reset during a burst with one trigger counted
    m_rise = 0; m_lat = 5;
    do_reset(3, 2'd2);
    for (int j = 0; j < 140; j++) step(1'b0, 1'b1, pat(2'd2, e));
    step(1'b1, 1'b1, pat(2'd2, e));
    step(1'b1, 1'b1, pat(2'd2, e));
    step(1'b0, 1'b1, pat(2'd2, e));
    do_reset(2, 2'd2);
    check(out_valid === 1'b0, "R9", "out_valid in reset mid-burst", 128'(out_valid), 128'(0));
    for (int j = 0; j < 12; j++) step(1'b0, 1'b1, pat(2'd2, e));
    check(out_valid === 1'b0, "R9", "no counted burst after reset", 128'(out_valid), 128'(0));

    // R3: mode switch to rise with constant-high inputs gives no fresh hits
    m_rise = 1; m_lat = 3;
    for (int j = 0; j < 6; j++) step(1'b0, 1'b1, '1);
    step(1'b1, 1'b1, '1);
    for (int j = 0; j < 6; j++) step(1'b0, 1'b1, '1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL R6 watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule